// File: doc/BRIEF.md
# MSI Vector-Entry Pending/Queued Gating Engine

This block decides what happens to one firing of a message-signalled interrupt source. Each source owns a 64-bit vector entry in a table held in system memory. The entry carries the target server, a priority, a pending flag (P), a queued flag (Q) and a two-bit generation value. A request names a source. The block checks the source against the table configuration and reads the entry with one 8-byte access. It then delivers the interrupt, records it as queued, or drops it.

The P and Q flags live only in memory, and the block changes them with single-byte writes. A delivery goes to the presenter port together with the server number, the priority and a global interrupt number. A retry path can set a force flag on the request. The flag makes the engine ignore the current flag state, so a rejected interrupt can be presented again.

Top module: `msi_pq_gate`

## Requirements
- R1: During and right after reset, `busy`, `mem_rd_en`, `mem_wr_en` and `dlv_valid` are low.
- R2: When `cfg_tbl_en` is low, an accepted request is abandoned. There is no memory access and no delivery, and `busy` stays low.
- R3: A source number greater than or equal to `cfg_tbl_len` is rejected with no memory access. Source `cfg_tbl_len`-1 is served normally.
- R4: A request is accepted on a clock edge where `busy` is low and `req_valid` is high. In the cycle after that edge, the block issues exactly one 8-byte read at the entry address. The entry address is the table base with its low four bits cleared, plus source × 128 when `cfg_wide_entry` is high, or plus source × 16 when it is low.
- R5: The read word is big-endian: the byte at the entry address is bits 63:56. The raw server is bits 63:48, and its low two bits are a link pointer. The delivered server is raw server >> 2. Priority is bits 47:40. P is bit 24, generation is bits 26:25 and Q is bit 16.
- R6: An unmasked entry with P clear causes a one-byte write at entry+4 of value 0x01 | (generation << 1). In that same cycle, two cycles after the read cycle, `dlv_valid` pulses for one cycle with the decoded server and priority. The Q flag does not affect this case.
- R7: `dlv_girq` equals the source number plus `cfg_irq_offset`, modulo 2^GIRQ_W.
- R8: An unmasked entry with P set and Q clear causes a one-byte write of 0x01 at entry+5, with no delivery.
- R9: An unmasked entry with both P and Q set causes no write and no delivery. The block is idle again two cycles after the read cycle.
- R10: A request with `req_force` high treats P and Q as both clear.
- R11: An entry with priority 0xFF is masked and never delivers. With Q clear, or on a forced request, it gets the Q write of R8. Otherwise nothing is written.
- R12: `busy` is high from the read cycle through the write cycle. Requests seen while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tbl_en | input | 1 | Table base enable |
| cfg_tbl_base | input | ADDR_W | Table base address (low 4 bits ignored) |
| cfg_tbl_len | input | SRC_W+1 | Number of valid sources |
| cfg_wide_entry | input | 1 | 1: 128-byte entry stride, 0: 16-byte |
| cfg_irq_offset | input | GIRQ_W | Added to source to form global number |
| req_valid | input | 1 | Fire request |
| req_src | input | SRC_W | Source number |
| req_force | input | 1 | Retry: treat P/Q as clear |
| busy | output | 1 | Request in flight |
| mem_rd_en | output | 1 | 8-byte read strobe |
| mem_wr_en | output | 1 | 1-byte write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 64 | Read word, big-endian |
| mem_rvalid | input | 1 | Read data valid |
| dlv_valid | output | 1 | Delivery pulse |
| dlv_server | output | 14 | Server number |
| dlv_prio | output | 8 | Priority |
| dlv_girq | output | GIRQ_W | Global interrupt number |

## Verification
Take the accept edge as edge 0 and a memory that answers one cycle after the read strobe. The read is then due in the cycle after edge 0. The flag write and any delivery come in the cycle after edge 2, and `busy` falls after edge 3. A drop returns the block to idle after edge 2. For a rejected request, nothing moves at all. The reference model works out the outcome from the bench's own memory image before driving the request. It then compares every output at each falling edge against the value due in that exact cycle, so an early, late or missing strobe counts as a miscompare.

// File: rtl/msi_pq_pkg.sv
package msi_pq_pkg;

    localparam int WORD_W     = 64;
    localparam int SERVER_W   = 14;
    localparam int PRIO_W     = 8;
    localparam int GEN_W      = 2;
    localparam int SRV_HI     = 63;
    localparam int SRV_LO     = 50;   // raw server bits 63:48, link pointer 49:48 dropped
    localparam int PRIO_HI    = 47;
    localparam int PRIO_LO    = 40;
    localparam int GEN_HI     = 26;
    localparam int GEN_LO     = 25;
    localparam int P_BIT      = 24;
    localparam int Q_BIT      = 16;
    localparam int P_BYTE_OFS = 4;
    localparam int Q_BYTE_OFS = 5;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_SETP,
        ST_SETQ
    } gate_state_e;

    typedef enum logic [1:0] {
        ACT_DROP,
        ACT_SETP,
        ACT_SETQ
    } gate_act_e;

    typedef struct packed {
        logic [SERVER_W-1:0] server;
        logic [PRIO_W-1:0]   prio;
        logic [GEN_W-1:0]    gen;
        logic                p;
        logic                q;
    } ive_fields_t;

endpackage

// File: rtl/msi_entry_addr.sv
module msi_entry_addr #(
    parameter int ADDR_W = 16,
    parameter int SRC_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [SRC_W-1:0]  src,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr
);
    localparam int NARROW_SH = 4;
    localparam int WIDE_SH   = 7;

    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] src_ext;
    logic              unused_base;

    assign base_al     = {base[ADDR_W-1:NARROW_SH], {NARROW_SH{1'b0}}};
    assign src_ext     = {{(ADDR_W-SRC_W){1'b0}}, src};
    assign addr        = base_al + (wide ? (src_ext << WIDE_SH) : (src_ext << NARROW_SH));
    assign unused_base = ^base[NARROW_SH-1:0];

endmodule

// File: rtl/msi_entry_decode.sv
module msi_entry_decode
    import msi_pq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ive_fields_t       fields
);
    logic unused_bits;

    always_comb begin
        fields.server = word[SRV_HI:SRV_LO];
        fields.prio   = word[PRIO_HI:PRIO_LO];
        fields.gen    = word[GEN_HI:GEN_LO];
        fields.p      = word[P_BIT];
        fields.q      = word[Q_BIT];
    end

    assign unused_bits = ^{word[49:48], word[39:27], word[23:17], word[15:0]};

endmodule

// File: rtl/msi_pq_decide.sv
module msi_pq_decide
    import msi_pq_pkg::*;
(
    input  logic              p,
    input  logic              q,
    input  logic [PRIO_W-1:0] prio,
    input  logic              force_req,
    output gate_act_e         act
);
    logic p_eff;
    logic q_eff;
    logic masked;

    always_comb begin
        p_eff  = p & ~force_req;
        q_eff  = q & ~force_req;
        masked = (prio == PRIO_MASKED);
        if (masked) begin
            act = q_eff ? ACT_DROP : ACT_SETQ;
        end else if (!p_eff) begin
            act = ACT_SETP;
        end else if (!q_eff) begin
            act = ACT_SETQ;
        end else begin
            act = ACT_DROP;
        end
    end

endmodule

// File: rtl/msi_pq_gate.sv
module msi_pq_gate
    import msi_pq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SRC_W  = 8,
    parameter int GIRQ_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_tbl_en,
    input  logic [ADDR_W-1:0]   cfg_tbl_base,
    input  logic [SRC_W:0]      cfg_tbl_len,
    input  logic                cfg_wide_entry,
    input  logic [GIRQ_W-1:0]   cfg_irq_offset,
    input  logic                req_valid,
    input  logic [SRC_W-1:0]    req_src,
    input  logic                req_force,
    output logic                busy,
    output logic                mem_rd_en,
    output logic                mem_wr_en,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_rvalid,
    output logic                dlv_valid,
    output logic [SERVER_W-1:0] dlv_server,
    output logic [PRIO_W-1:0]   dlv_prio,
    output logic [GIRQ_W-1:0]   dlv_girq
);

    typedef struct packed {
        gate_state_e       st;
        logic [SRC_W-1:0]  src;
        logic              frc;
        logic [ADDR_W-1:0] eaddr;
        ive_fields_t       ive;
    } gate_regs_t;

    gate_regs_t  regs_d, regs_q;
    logic [ADDR_W-1:0] calc_addr;
    ive_fields_t       rd_fields;
    gate_act_e         act;
    logic              src_ok;

    msi_entry_addr #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) addr_i (
        .base (cfg_tbl_base),
        .src  (req_src),
        .wide (cfg_wide_entry),
        .addr (calc_addr)
    );

    msi_entry_decode dec_i (
        .word   (mem_rdata),
        .fields (rd_fields)
    );

    msi_pq_decide dcd_i (
        .p         (rd_fields.p),
        .q         (rd_fields.q),
        .prio      (rd_fields.prio),
        .force_req (regs_q.frc),
        .act       (act)
    );

    assign src_ok = cfg_tbl_en && ({1'b0, req_src} < cfg_tbl_len);

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (req_valid && src_ok) begin
                    regs_d.st    = ST_READ;
                    regs_d.src   = req_src;
                    regs_d.frc   = req_force;
                    regs_d.eaddr = calc_addr;
                end
            end
            ST_READ: regs_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    regs_d.ive = rd_fields;
                    case (act)
                        ACT_SETP: regs_d.st = ST_SETP;
                        ACT_SETQ: regs_d.st = ST_SETQ;
                        default:  regs_d.st = ST_IDLE;
                    endcase
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        busy       = (regs_q.st != ST_IDLE);
        mem_rd_en  = (regs_q.st == ST_READ);
        mem_wr_en  = (regs_q.st == ST_SETP) || (regs_q.st == ST_SETQ);
        dlv_valid  = (regs_q.st == ST_SETP);
        mem_addr   = regs_q.eaddr;
        mem_wdata  = 8'h01;
        if (regs_q.st == ST_SETP) begin
            mem_addr  = regs_q.eaddr + ADDR_W'(P_BYTE_OFS);
            mem_wdata = {5'b0, regs_q.ive.gen, 1'b1};
        end else if (regs_q.st == ST_SETQ) begin
            mem_addr  = regs_q.eaddr + ADDR_W'(Q_BYTE_OFS);
        end
        dlv_server = regs_q.ive.server;
        dlv_prio   = regs_q.ive.prio;
        dlv_girq   = {{(GIRQ_W-SRC_W){1'b0}}, regs_q.src} + cfg_irq_offset;
    end

    // R12: read and write strobes never coincide
    p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R4: one read strobe per request
    p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R2: disabled table gives no read
    p_disabled_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && !cfg_tbl_en) |=> !mem_rd_en);

    // R3: out-of-range source gives no read
    p_oob_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && ({1'b0, req_src} >= cfg_tbl_len)) |=> !mem_rd_en);

    // R11: masked entry never delivers
    p_masked_no_dlv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_WAIT && mem_rvalid && mem_rdata[PRIO_HI:PRIO_LO] == PRIO_MASKED)
        |=> !dlv_valid);

    // R6: a delivery always follows returned entry data
    p_dlv_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> $past(mem_rvalid));

endmodule

// File: tb/msi_pq_gate_tb_top.sv
`timescale 1ns/1ps
module msi_pq_gate_tb_top;

    localparam int CLK_HALF = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tbl_en = 1'b1;
    logic [15:0] cfg_tbl_base = 16'h0105;
    logic [8:0]  cfg_tbl_len = 9'd16;
    logic        cfg_wide_entry = 1'b0;
    logic [11:0] cfg_irq_offset = 12'h200;
    logic        req_valid = 1'b0;
    logic [7:0]  req_src = '0;
    logic        req_force = 1'b0;
    logic        busy, mem_rd_en, mem_wr_en, dlv_valid;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [13:0] dlv_server;
    logic [7:0]  dlv_prio;
    logic [11:0] dlv_girq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:4095];

    always #CLK_HALF clk = ~clk;

    msi_pq_gate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tbl_en(cfg_tbl_en), .cfg_tbl_base(cfg_tbl_base),
        .cfg_tbl_len(cfg_tbl_len), .cfg_wide_entry(cfg_wide_entry),
        .cfg_irq_offset(cfg_irq_offset), .req_valid(req_valid), .req_src(req_src),
        .req_force(req_force), .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .dlv_valid(dlv_valid), .dlv_server(dlv_server),
        .dlv_prio(dlv_prio), .dlv_girq(dlv_girq)
    );

    // behavioural memory: big-endian word read, one-cycle latency
    always @(posedge clk) begin
        mem_rvalid <= mem_rd_en;
        if (mem_rd_en) begin
            for (int b = 0; b < 8; b++) mem_rdata[63-8*b -: 8] <= mem[(mem_addr + b) & 16'h0FFF];
        end
        if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input bit eb, input bit er, input bit ew, input bit ed,
                       input int ea, input int ewd, input int esv, input int epr, input int egi);
        bit bad;
        bad = (busy !== eb) || (mem_rd_en !== er) || (mem_wr_en !== ew) || (dlv_valid !== ed);
        if ((er || ew) && mem_addr !== 16'(ea)) bad = 1;
        if (ew && mem_wdata !== 8'(ewd)) bad = 1;
        if (ed && (dlv_server !== 14'(esv) || dlv_prio !== 8'(epr) || dlv_girq !== 12'(egi))) bad = 1;
        vectors++;
        if (bad) begin
            miscompares++;
            $display("FAIL %s t=%0t actual busy=%b rd=%b wr=%b dlv=%b addr=%h wd=%h srv=%h pr=%h gi=%h expected busy=%b rd=%b wr=%b dlv=%b addr=%h wd=%h srv=%h pr=%h gi=%h",
                     tag, $time, busy, mem_rd_en, mem_wr_en, dlv_valid, mem_addr, mem_wdata,
                     dlv_server, dlv_prio, dlv_girq, eb, er, ew, ed, ea[15:0], ewd[7:0],
                     esv[13:0], epr[7:0], egi[11:0]);
        end
    endtask

    task automatic set_entry(input int a, input int srv, input int prio, input int gen,
                             input bit p, input bit q);
        mem[a]   = 8'(srv >> 8);
        mem[a+1] = 8'(srv);
        mem[a+2] = 8'(prio);
        mem[a+3] = 8'h00;
        mem[a+4] = {5'b0, 2'(gen), p};
        mem[a+5] = {7'b0, q};
        mem[a+6] = 8'h00;
        mem[a+7] = 8'h00;
    endtask

    function automatic int entry_addr(input int src);
        return (int'(cfg_tbl_base) & 'hFFF0) + src * (cfg_wide_entry ? 128 : 16);
    endfunction

    // reference model: outcome from memory image, then per-cycle comparison
    task automatic fire(input int src, input bit frc, input bit overlap, input string tag);
        bit ok, masked, pe, qe;
        int ea, srv, prio, gen, kind, gi;
        ok   = cfg_tbl_en && (src < int'(cfg_tbl_len));
        ea   = entry_addr(src);
        kind = 0;
        srv = 0; prio = 0; gen = 0;
        if (ok) begin
            srv    = ({mem[ea], mem[ea+1]}) >> 2;
            prio   = mem[ea+2];
            gen    = (mem[ea+4] >> 1) & 3;
            pe     = mem[ea+4][0] && !frc;
            qe     = mem[ea+5][0] && !frc;
            masked = (prio == 'hFF);
            if (masked) kind = qe ? 0 : 2;
            else if (!pe) kind = 1;
            else if (!qe) kind = 2;
            else kind = 0;
        end
        gi = (src + int'(cfg_irq_offset)) % 4096;
        @(negedge clk);
        req_valid = 1'b1; req_src = 8'(src); req_force = frc;
        @(negedge clk);
        if (overlap) req_src = 8'(src ^ 1);
        else req_valid = 1'b0;
        if (!ok) begin
            chk(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            @(negedge clk);
            chk(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end else begin
            chk(tag, 1, 1, 0, 0, ea, 0, 0, 0, 0);
            @(negedge clk);
            chk(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0);
            @(negedge clk);
            if (kind == 1)      chk(tag, 1, 0, 1, 1, ea + 4, 1 | (gen << 1), srv, prio, gi);
            else if (kind == 2) chk(tag, 1, 0, 1, 0, ea + 5, 1, 0, 0, 0);
            else                chk(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            req_valid = 1'b0;
            @(negedge clk);
            chk(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            @(negedge clk);
            chk(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        set_entry(16'h100 + 3*16,  'h0123, 'h05, 2, 0, 0);
        set_entry(16'h100 + 15*16, 'hFFFF, 'h10, 3, 0, 0);
        set_entry(16'h100 + 5*16,  'h0040, 'hFF, 1, 0, 0);
        set_entry(16'h100 + 6*16,  'h0209, 'h22, 0, 0, 1);
        set_entry(16'h100 + 7*16,  'h0300, 'h01, 1, 0, 0);
        set_entry(16'h100 + 2*128, 'h1ABE, 'h07, 1, 0, 0);
        repeat (2) @(negedge clk);
        chk("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);

        fire(3, 0, 0, "R6");     // P clear: set P, deliver
        fire(3, 0, 0, "R8");     // P set: set Q
        fire(3, 0, 0, "R9");     // both set: drop
        fire(3, 1, 0, "R10");    // forced: deliver anyway
        fire(15, 0, 0, "R3");    // last valid source, raw server link bits dropped
        fire(16, 0, 0, "R3");    // out of range
        fire(5, 0, 0, "R11");    // masked, Q clear: Q write only
        fire(5, 0, 0, "R11");    // masked, Q set: drop
        fire(5, 1, 0, "R11");    // masked forced: Q write, no delivery
        fire(6, 0, 0, "R5");     // P clear with Q set still delivers
        fire(7, 0, 1, "R12");    // requests held during busy are ignored
        cfg_tbl_en = 1'b0;
        fire(3, 0, 0, "R2");
        cfg_tbl_en = 1'b1;
        cfg_wide_entry = 1'b1;
        cfg_irq_offset = 12'hFFF;
        fire(2, 0, 0, "R4");     // 128-byte stride, base low bits masked
        fire(2, 0, 0, "R7");     // wrapped global number on Q path: P now set
        cfg_wide_entry = 1'b0;
        fire(7, 1, 0, "R7");     // forced delivery with wrapped global number

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule